// File: doc/BRIEF.md
# Bus Grant and Status Arbiter

This block sits beside a processor's execution engine. It decides in which bus cycles the processor owns the shared address, data and direction lines, and in which cycles it hands them to an external master. It also reports the processor state on two status outputs, `ba` and `bs`. Two things can take the buses away:

- A halt request, which waits for an instruction boundary and lasts as long as it is held.
- A bus request, which acts at the end of the current bus cycle and is limited to `MAX_GRANT` bus cycles of ownership.

Each change of mastership is padded with a dead cycle. An external qualifier goes low in any bus cycle in which `ba` changes, so that no false access is made during a handover. A separate output tells the address and direction drivers to present the idle pattern: address all ones, direction read.

Every register advances only on bus cycles marked by `cyc_end`. One such cycle is one bus cycle.

Top module: `bus_grant_arbiter`

## Requirements
- R1: During and after reset the status pair {ba,bs} is 00, `bus_oe` is 1 and `dma_vma` is 1.
- R2: While the processor runs, {ba,bs} in the next bus cycle encodes the acknowledge inputs sampled at cycle end: 10 if `sync_ack` is set (it wins), 01 if only `irq_ack` is set, 00 otherwise.
- R3: A `bus_req` seen at a bus-cycle end while running gives {ba,bs}=11 in the next bus cycle, whatever the state of `instr_end`.
- R4: A `halt_req` has no effect until a bus cycle that ends with `instr_end` high; after that cycle {ba,bs}=11.
- R5: Once halted, {ba,bs} stays 11 for as long as `halt_req` stays high, and `ba` falls in the bus cycle after `halt_req` is seen low.
- R6: When `bus_req` is held, `ba` stays high for exactly MAX_GRANT+1 bus cycles: one dead cycle plus MAX_GRANT granted cycles. Dropping `bus_req` during the grant ends it after the current cycle.
- R7: After `ba` falls, `bus_oe` stays low for one more bus cycle. At least one driven processor cycle follows before a held `bus_req` raises `ba` again.
- R8: `bus_oe` is 0 in every bus cycle with `ba` high.
- R9: `dma_vma` is 0 exactly in the bus cycles in which `ba` differs from its value in the previous bus cycle, and 1 otherwise.
- R10: `force_idle` is 1 whenever `bus_oe` is 0 or `access_valid` is 0, and 0 otherwise.
- R11: While `cyc_end` is low, `ba`, `bs`, `bus_oe` and `dma_vma` do not change.
- R12: The MAX_GRANT limit does not apply to a halt. A halted processor keeps {ba,bs}=11 past MAX_GRANT+1 cycles, even while `bus_req` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cyc_end | input | 1 | Marks the last clock of a bus cycle; enables all state updates |
| instr_end | input | 1 | Current bus cycle is the last of an instruction |
| halt_req | input | 1 | Halt request, active high |
| bus_req | input | 1 | Bus request from an external master, active high |
| irq_ack | input | 1 | Engine is in an interrupt or reset acknowledge cycle |
| sync_ack | input | 1 | Engine is waiting in sync acknowledge |
| access_valid | input | 1 | Engine performs a real memory access this cycle |
| ba | output | 1 | Bus-available status bit |
| bs | output | 1 | Bus-state status bit |
| bus_oe | output | 1 | Enable for the address, data and direction drivers |
| dma_vma | output | 1 | Valid-access qualifier for external masters; low while `ba` changes |
| force_idle | output | 1 | Force the address to all ones and the direction to read |

## Verification
The bench targets the grant limit with `bus_req` held. A counter that is off by one would hold `ba` for 15 or 17 cycles instead of 16. A design that skips the processor's own cycle after reclaiming the bus would raise `ba` again straight after the reclaim dead cycle.

It checks that a halt request is ignored until an instruction boundary. A design that treated it like a bus request would raise `ba` early. It also checks that a long halt is not cut short by the grant limit.

The trailing dead cycle is checked after a grant and after sync acknowledge. A design that dropped it would re-enable the drivers in the same cycle `ba` falls. Stretched bus cycles, with `cyc_end` low, must freeze every status output, including a pending grant.

// File: rtl/bga_pkg.sv
`timescale 1ns/1ps
package bga_pkg;
  typedef enum logic [2:0] {
    ST_RUN       = 3'd0,
    ST_HALT_DEAD = 3'd1,
    ST_HALTED    = 3'd2,
    ST_DMA_DEAD  = 3'd3,
    ST_DMA       = 3'd4,
    ST_BACK      = 3'd5
  } arb_state_e;
endpackage

// File: rtl/bga_grant_fsm.sv
`timescale 1ns/1ps
module bga_grant_fsm
  import bga_pkg::*;
#(
  parameter int MAX_GRANT = 15
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cyc_end,
  input  logic       instr_end,
  input  logic       halt_req,
  input  logic       bus_req,
  output arb_state_e state_d
);
  localparam int CW = $clog2(MAX_GRANT + 1);
  localparam logic [CW-1:0] LAST = CW'(MAX_GRANT - 1);

  arb_state_e    state_q;
  logic [CW-1:0] cnt_q, cnt_d;

  // next-state process
  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    unique case (state_q)
      ST_RUN: begin
        if (bus_req)                    state_d = ST_DMA_DEAD;
        else if (halt_req && instr_end) state_d = ST_HALT_DEAD;
      end
      ST_HALT_DEAD: state_d = ST_HALTED;
      ST_HALTED:    if (!halt_req) state_d = ST_BACK;
      ST_DMA_DEAD: begin
        state_d = ST_DMA;
        cnt_d   = '0;
      end
      ST_DMA: begin
        if (!bus_req || cnt_q == LAST) state_d = ST_BACK;
        else                           cnt_d   = cnt_q + 1'b1;
      end
      ST_BACK: state_d = ST_RUN;
      default: state_d = ST_RUN;
    endcase
  end

  // register process, advanced once per bus cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_RUN;
      cnt_q   <= '0;
    end else if (cyc_end) begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

  // checker: consecutive granted bus cycles held by the external master
  logic [CW:0] chk_run_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                               chk_run_q <= '0;
    else if (cyc_end && state_d == ST_DMA)    chk_run_q <= chk_run_q + 1'b1;
    else if (cyc_end)                         chk_run_q <= '0;
  end

  p_grant_limit_r6: assert property (@(posedge clk) disable iff (!rst_n)
    chk_run_q <= (CW+1)'(MAX_GRANT));

  p_breq_grants_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_RUN && cyc_end && bus_req) |=> state_q == ST_DMA_DEAD);

  p_halt_boundary_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_RUN && cyc_end && !bus_req && !instr_end) |=> state_q == ST_RUN);

  p_halt_holds_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_HALTED && halt_req) |=> state_q == ST_HALTED);
endmodule

// File: rtl/bga_status_reg.sv
`timescale 1ns/1ps
module bga_status_reg
  import bga_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cyc_end,
  input  arb_state_e state_d,
  input  logic       irq_ack,
  input  logic       sync_ack,
  input  logic       access_valid,
  output logic       ba,
  output logic       bs,
  output logic       bus_oe,
  output logic       dma_vma,
  output logic       force_idle
);
  logic ba_d, bs_d;
  logic ba_q, bs_q, ba_prev_q;

  // status encoding for the coming bus cycle
  always_comb begin
    unique case (state_d)
      ST_RUN: begin
        ba_d = sync_ack;
        bs_d = irq_ack && !sync_ack;
      end
      ST_BACK: begin
        ba_d = 1'b0;
        bs_d = 1'b0;
      end
      default: begin
        ba_d = 1'b1;
        bs_d = 1'b1;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ba_q      <= 1'b0;
      bs_q      <= 1'b0;
      ba_prev_q <= 1'b0;
    end else if (cyc_end) begin
      ba_q      <= ba_d;
      bs_q      <= bs_d;
      ba_prev_q <= ba_q;
    end
  end

  assign ba         = ba_q;
  assign bs         = bs_q;
  assign bus_oe     = !ba_q && !ba_prev_q;
  assign dma_vma    = (ba_q == ba_prev_q);
  assign force_idle = !bus_oe || !access_valid;

  p_trail_dead_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ba_q) |-> !bus_oe);

  p_vma_on_edge_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(ba_q) || $fell(ba_q)) |-> !dma_vma);
endmodule

// File: rtl/bus_grant_arbiter.sv
`timescale 1ns/1ps
module bus_grant_arbiter
  import bga_pkg::*;
#(
  parameter int MAX_GRANT = 15
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cyc_end,
  input  logic instr_end,
  input  logic halt_req,
  input  logic bus_req,
  input  logic irq_ack,
  input  logic sync_ack,
  input  logic access_valid,
  output logic ba,
  output logic bs,
  output logic bus_oe,
  output logic dma_vma,
  output logic force_idle
);
  arb_state_e state_d;

  bga_grant_fsm #(.MAX_GRANT(MAX_GRANT)) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .cyc_end   (cyc_end),
    .instr_end (instr_end),
    .halt_req  (halt_req),
    .bus_req   (bus_req),
    .state_d   (state_d)
  );

  bga_status_reg u_status (
    .clk          (clk),
    .rst_n        (rst_n),
    .cyc_end      (cyc_end),
    .state_d      (state_d),
    .irq_ack      (irq_ack),
    .sync_ack     (sync_ack),
    .access_valid (access_valid),
    .ba           (ba),
    .bs           (bs),
    .bus_oe       (bus_oe),
    .dma_vma      (dma_vma),
    .force_idle   (force_idle)
  );

  p_float_when_ba_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ba |-> !bus_oe);

  p_idle_forced_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_oe |-> force_idle);

  p_stretch_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !cyc_end |=> ($stable(ba) && $stable(bs)));
endmodule

// File: tb/bus_grant_arbiter_bench.sv
`timescale 1ns/1ps
module bus_grant_arbiter_bench;
  localparam int MAXG = 15;

  logic clk = 1'b0;
  logic rst_n, cyc_end, instr_end, halt_req, bus_req, irq_ack, sync_ack, access_valid;
  logic ba, bs, bus_oe, dma_vma, force_idle;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  bus_grant_arbiter #(.MAX_GRANT(MAXG)) u_bus_grant_arbiter (
    .clk(clk), .rst_n(rst_n), .cyc_end(cyc_end), .instr_end(instr_end),
    .halt_req(halt_req), .bus_req(bus_req), .irq_ack(irq_ack), .sync_ack(sync_ack),
    .access_valid(access_valid), .ba(ba), .bs(bs), .bus_oe(bus_oe),
    .dma_vma(dma_vma), .force_idle(force_idle)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // one clock edge, then settle at the falling edge
  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset();
    rst_n = 1'b0; cyc_end = 1'b1; instr_end = 1'b0; halt_req = 1'b0;
    bus_req = 1'b0; irq_ack = 1'b0; sync_ack = 1'b0; access_valid = 1'b1;
    repeat (3) step();
    chk("R1 status in reset", {ba, bs}, 0);
    chk("R1 oe in reset", bus_oe, 1);
    chk("R1 vma in reset", dma_vma, 1);
    rst_n = 1'b1;
    step();
    chk("R1 status after reset", {ba, bs}, 0);
    chk("R1 oe after reset", bus_oe, 1);
  endtask

  task automatic t_status_r2();
    irq_ack = 1'b1; step();
    chk("R2 irq ack", {ba, bs}, 1);
    sync_ack = 1'b1; step();
    chk("R2 sync wins", {ba, bs}, 2);
    chk("R8 oe with sync", bus_oe, 0);
    chk("R9 vma on rise", dma_vma, 0);
    sync_ack = 1'b0; irq_ack = 1'b0; step();
    chk("R2 back to run", {ba, bs}, 0);
    chk("R7 trailing dead", bus_oe, 0);
    chk("R9 vma on fall", dma_vma, 0);
    step();
    chk("R7 driven again", bus_oe, 1);
    chk("R9 vma steady", dma_vma, 1);
  endtask

  task automatic t_grant_limit_r6();
    int hi;
    bus_req = 1'b1;
    step();
    chk("R3 grant mid instruction", {ba, bs}, 3);
    chk("R9 vma grant dead", dma_vma, 0);
    chk("R10 idle forced", force_idle, 1);
    hi = 1;
    for (int i = 0; i < 40 && ba; i++) begin
      step();
      if (ba) hi++;
    end
    chk("R6 held cycles", hi, MAXG + 1);
    chk("R7 reclaim dead oe", bus_oe, 0);
    step();
    chk("R7 processor cycle oe", bus_oe, 1);
    chk("R7 processor cycle ba", ba, 0);
    step();
    chk("R7 regrant", {ba, bs}, 3);
    bus_req = 1'b0;
    step(); step();
    chk("R6 released", ba, 0);
    step();
    chk("R6 oe back", bus_oe, 1);
  endtask

  task automatic t_early_release_r6();
    bus_req = 1'b1; step();
    step();
    chk("R6 granted", ba, 1);
    bus_req = 1'b0; step();
    chk("R6 early end", ba, 0);
    step();
  endtask

  task automatic t_halt();
    halt_req = 1'b1; instr_end = 1'b0;
    repeat (3) step();
    chk("R4 no halt mid instruction", {ba, bs}, 0);
    instr_end = 1'b1; step();
    instr_end = 1'b0;
    chk("R4 halt at boundary", {ba, bs}, 3);
    bus_req = 1'b1;
    repeat (MAXG + 6) step();
    chk("R12 halt outlasts limit", {ba, bs}, 3);
    chk("R5 halt held", ba, 1);
    bus_req = 1'b0; halt_req = 1'b0; step();
    chk("R5 ba falls", ba, 0);
    chk("R7 halt trailing", bus_oe, 0);
    step();
    chk("R5 running", bus_oe, 1);
  endtask

  task automatic t_stretch_r11();
    bus_req = 1'b1; cyc_end = 1'b0;
    repeat (3) step();
    chk("R11 no grant while stretched", ba, 0);
    cyc_end = 1'b1; step();
    chk("R11 grant at cycle end", ba, 1);
    cyc_end = 1'b0; bus_req = 1'b0;
    repeat (3) step();
    chk("R11 ba frozen", ba, 1);
    chk("R11 vma frozen", dma_vma, 0);
    cyc_end = 1'b1; step();
    chk("R11 grant cycle", ba, 1);
    step();
    chk("R11 released", ba, 0);
    step();
  endtask

  task automatic t_idle_r10();
    access_valid = 1'b0; #1;
    chk("R10 no access", force_idle, 1);
    access_valid = 1'b1; #1;
    chk("R10 real access", force_idle, 0);
  endtask

  initial begin
    t_reset();
    t_status_r2();
    t_grant_limit_r6();
    t_early_release_r6();
    t_halt();
    t_stretch_r11();
    t_idle_r10();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule